// File: doc/BRIEF.md
# Linear Address Space Separation Checker

This block screens a 64-bit linear address before it reaches translation. It first confirms the address is canonical for the configured virtual-address width. If that passes, and the core is in 64-bit mode with the separation control turned on, it applies a user/supervisor split keyed on address bit 63. In that split a user-mode access may only touch the lower half. A supervisor instruction fetch may only touch the upper half. A supervisor data access to the lower half is refused only when supervisor access protection is on and the alignment-check flag is clear.

A request is presented for one cycle with `req_valid`, together with the address, the access kind and the context bits. One clock later `rsp_valid` rises and `rsp_ok` gives the verdict. Requests may be issued back to back, one per cycle. Translation and fault delivery belong to the consumers of `rsp_ok`.

Top module: `lass_addr_checker`

## Requirements
- R1: An address whose bits 63 down to VA_BITS-1 are not all equal is refused (`rsp_ok`=0), whatever the kind and context inputs are.
- R2: A canonical address is accepted when `req_long` is 0 or `req_sep` is 0, whatever the other inputs are.
- R3: With `req_long`=1 and `req_sep`=1, a canonical user-mode access (`req_user`=1) with address bit 63 = 1 is refused.
- R4: With `req_long`=1 and `req_sep`=1, a canonical user-mode access with address bit 63 = 0 is accepted, for every kind.
- R5: With `req_long`=1 and `req_sep`=1, a canonical supervisor access (`req_user`=0) of kind fetch (`req_kind`=2'b10) with bit 63 = 0 is refused, whatever `req_smap` and `req_ac` are.
- R6: With `req_long`=1 and `req_sep`=1, a canonical supervisor data access (`req_kind` 2'b00 read, 2'b01 write, or 2'b11, which is treated as data) with bit 63 = 0 is refused exactly when `req_smap`=1 and `req_ac`=0, and is accepted otherwise.
- R7: With `req_long`=1 and `req_sep`=1, a canonical supervisor access with bit 63 = 1 is accepted for every kind.
- R8: `rsp_valid` equals `req_valid` of the previous cycle. After reset, `rsp_valid` and `rsp_ok` are 0. `rsp_ok` is 0 whenever `rsp_valid` is 0.
- R9: With VA_BITS = 57, canonical form covers bits 63 down to 56. An address with bits 63:56 all zero but a 1 among bits 55:47 is canonical there, yet it is refused when VA_BITS = 48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_addr | input | 64 | Linear address to check |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 treated as data |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| req_long | input | 1 | 64-bit mode is active |
| req_sep | input | 1 | Address space separation enabled |
| req_smap | input | 1 | Supervisor access protection enabled |
| req_ac | input | 1 | Alignment-check flag |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_ok | output | 1 | 1 = access allowed, 0 = refused |

## Verification
The properties assume the context bits and kind are stable only in the cycle of `req_valid`. Each property relates that cycle's inputs to the next cycle's verdict, so no hold time is assumed. They also assume that every 2-bit kind code is legal, with 2'b11 behaving as data. The random stimulus draws all four kind codes freely. It builds addresses from four families: low canonical, high canonical, fully random, and 57-bit-only canonical. This way both the canonical screen and the split are exercised with the context bits biased toward separation being active.

// File: rtl/lass_pkg.sv
package lass_pkg;

    localparam int unsigned ADDR_W = 64;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_OTHER = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic user;
        logic long_mode;
        logic sep_en;
        logic smap_en;
        logic ac_flag;
    } acc_ctx_t;

    typedef struct packed {
        logic canonical;
        logic split_ok;
    } verdict_t;

    function automatic logic upper_half(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

endpackage

// File: rtl/lass_canon.sv
module lass_canon #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned VA_BITS = 48
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              canonical
);
    localparam int unsigned HI_W = ADDR_W - VA_BITS + 1;

    generate
        if (VA_BITS >= ADDR_W) begin : g_full
            assign canonical = 1'b1;
        end else begin : g_ext
            logic [HI_W-1:0] hi;
            assign hi        = addr[ADDR_W-1:VA_BITS-1];
            assign canonical = (&hi) | ~(|hi);
        end
    endgenerate
endmodule

// File: rtl/lass_policy.sv
module lass_policy
    import lass_pkg::*;
(
    input  logic      sup_half,
    input  acc_kind_e kind,
    input  acc_ctx_t  ctx,
    output logic      allow
);
    logic active;
    assign active = ctx.long_mode & ctx.sep_en;

    always_comb begin
        if (!active) begin
            allow = 1'b1;
        end else if (ctx.user) begin
            allow = ~sup_half;
        end else if (sup_half) begin
            allow = 1'b1;
        end else if (kind == ACC_FETCH) begin
            allow = 1'b0;
        end else begin
            allow = ~(ctx.smap_en & ~ctx.ac_flag);
        end
    end
endmodule

// File: rtl/lass_addr_checker.sv
module lass_addr_checker
    import lass_pkg::*;
#(
    parameter int unsigned VA_BITS = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [63:0] req_addr,
    input  logic [1:0]  req_kind,
    input  logic        req_user,
    input  logic        req_long,
    input  logic        req_sep,
    input  logic        req_smap,
    input  logic        req_ac,
    output logic        rsp_valid,
    output logic        rsp_ok
);
    acc_ctx_t  ctx;
    acc_kind_e kind;
    verdict_t  v;

    assign ctx  = '{user: req_user, long_mode: req_long, sep_en: req_sep,
                    smap_en: req_smap, ac_flag: req_ac};
    assign kind = acc_kind_e'(req_kind);

    lass_canon #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_canon (
        .addr      (req_addr),
        .canonical (v.canonical)
    );

    lass_policy u_policy (
        .sup_half (upper_half(req_addr)),
        .kind     (kind),
        .ctx      (ctx),
        .allow    (v.split_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= req_valid & v.canonical & v.split_ok;
        end
    end
endmodule

// File: rtl/lass_addr_checker_sva.sv
module lass_addr_checker_sva #(
    parameter int unsigned VA_BITS = 48
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [63:0] req_addr,
    input logic [1:0]  req_kind,
    input logic        req_user,
    input logic        req_long,
    input logic        req_sep,
    input logic        req_smap,
    input logic        req_ac,
    input logic        rsp_valid,
    input logic        rsp_ok
);
    localparam int unsigned SH = 64 - VA_BITS;

    logic        canon;
    logic        on;
    logic [63:0] ext;
    assign ext   = 64'($signed(req_addr << SH) >>> SH);
    assign canon = (ext == req_addr);
    assign on    = req_valid & canon & req_long & req_sep;

    assert_noncanon_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !canon) |=> !rsp_ok);
    assert_inactive_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && canon && !(req_long && req_sep)) |=> rsp_ok);
    assert_user_sup_R3: assert property (@(posedge clk) disable iff (rst)
        (on && req_user && req_addr[63]) |=> !rsp_ok);
    assert_user_low_R4: assert property (@(posedge clk) disable iff (rst)
        (on && req_user && !req_addr[63]) |=> rsp_ok);
    assert_sup_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        (on && !req_user && !req_addr[63] && req_kind == 2'b10) |=> !rsp_ok);
    assert_sup_data_R6: assert property (@(posedge clk) disable iff (rst)
        (on && !req_user && !req_addr[63] && req_kind != 2'b10)
        |=> (rsp_ok == !($past(req_smap) && !$past(req_ac))));
    assert_sup_high_R7: assert property (@(posedge clk) disable iff (rst)
        (on && !req_user && req_addr[63]) |=> rsp_ok);
    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_valid_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_ok_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_ok);
endmodule

bind lass_addr_checker lass_addr_checker_sva #(.VA_BITS(VA_BITS)) u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_user(req_user), .req_long(req_long),
    .req_sep(req_sep), .req_smap(req_smap), .req_ac(req_ac),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
);

// File: tb/lass_addr_checker_tb.sv
module lass_addr_checker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0, req_long = 1'b0, req_sep = 1'b0;
    logic        req_smap = 1'b0, req_ac = 1'b0;
    logic        v48, ok48, v57, ok57;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    lass_addr_checker #(.VA_BITS(48)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_user(req_user), .req_long(req_long),
        .req_sep(req_sep), .req_smap(req_smap), .req_ac(req_ac),
        .rsp_valid(v48), .rsp_ok(ok48));

    lass_addr_checker #(.VA_BITS(57)) u_dut57 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_user(req_user), .req_long(req_long),
        .req_sep(req_sep), .req_smap(req_smap), .req_ac(req_ac),
        .rsp_valid(v57), .rsp_ok(ok57));

    function automatic bit model_canon(input logic [63:0] a, input int vab);
        for (int i = vab; i < 64; i++)
            if (a[i] != a[vab-1]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit model_ok(input logic [63:0] a, input logic [1:0] k,
        input bit u, input bit lm, input bit sp, input bit sm, input bit ac, input int vab);
        if (!model_canon(a, vab)) return 1'b0;
        if (!(lm && sp)) return 1'b1;
        if (u) return !a[63];
        if (a[63]) return 1'b1;
        if (k == 2'b10) return 1'b0;
        return !(sm && !ac);
    endfunction

    function automatic string tag(input logic [63:0] a, input logic [1:0] k,
        input bit u, input bit lm, input bit sp, input int vab);
        if (!model_canon(a, vab)) return "R1";
        if (!(lm && sp)) return "R2";
        if (u) return a[63] ? "R3" : "R4";
        if (a[63]) return "R7";
        return (k == 2'b10) ? "R5" : "R6";
    endfunction

    task automatic check(input string r, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (addr %h kind %b u%b l%b s%b m%b a%b)",
                     r, act, exp, req_addr, req_kind, req_user, req_long, req_sep,
                     req_smap, req_ac);
        end
    endtask

    task automatic issue(input logic [63:0] a, input logic [1:0] k, input bit u,
        input bit lm, input bit sp, input bit sm, input bit ac);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k; req_user = u;
        req_long = lm; req_sep = sp; req_smap = sm; req_ac = ac;
        @(posedge clk); #2;
        check("R8", v48, 1'b1);
        check(tag(a, k, u, lm, sp, 48), ok48, model_ok(a, k, u, lm, sp, sm, ac, 48));
        check(model_canon(a, 48) != model_canon(a, 57) ? "R9" : tag(a, k, u, lm, sp, 57),
              ok57, model_ok(a, k, u, lm, sp, sm, ac, 57));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 64'hFFFF_FFFF_FFFF_FFFF;
        @(posedge clk); #2;
        check("R8", v48, 1'b0);
        check("R8", ok48, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        check("R8", v48, 1'b0);
        check("R8", ok48, 1'b0);
        @(negedge clk); rst = 1'b0;
        idle();

        // directed corners
        issue(64'h0000_8000_0000_0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R1 / R9
        issue(64'h0000_8000_0000_0000, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R9 user low in 57
        issue(64'h8000_0000_0000_0000, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R1 both
        issue(64'h0000_7FFF_FFFF_FFFF, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R4
        issue(64'hFFFF_8000_0000_0000, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); // R3
        issue(64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R2
        issue(64'h0000_0000_0000_1000, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); // R5
        issue(64'h0000_0000_0000_1000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R6 refuse
        issue(64'h0000_0000_0000_1000, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // R6 ac set
        issue(64'h0000_0000_0000_1000, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R6 smap off
        issue(64'hFFFF_8000_0000_0000, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R7
        issue(64'h00FF_FFFF_FFFF_FFFF, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R9 / R2
        idle();

        for (int n = 0; n < 600; n++) begin
            logic [63:0] a;
            logic [46:0] lo;
            int fam;
            lo  = {$urandom, $urandom} & 47'h7FFF_FFFF_FFFF;
            fam = $urandom_range(0, 3);
            case (fam)
                0: a = {17'h0, lo};
                1: a = {17'h1FFFF, lo};
                2: a = {$urandom, $urandom};
                default: a = {8'h00, $urandom_range(0, 511) > 0 ? 9'($urandom) : 9'h0, lo};
            endcase
            issue(a, 2'($urandom), 1'($urandom),
                  $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                  1'($urandom), 1'($urandom));
            if ($urandom_range(0, 7) == 0) idle();
        end
        idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule